// File: doc/BRIEF.md
# SPI Serial EEPROM Command Front End

This block is the slave side of a four-wire serial link in front of a 512-byte nonvolatile memory model. It samples chip select, serial clock and serial input with the system clock. It shifts in an 8-bit instruction and decodes six commands. Array reads and status reads are served directly from a synchronous RAM port and from live status inputs. The serial output is a data bit plus a drive enable, so the pad or a separate hold gate can tristate it.

Commands that change state are not carried out here. Write-enable set and clear, status writes and array writes go to a separate programming controller as single-cycle requests, each carrying a kind, an address and a data byte. A commit pulse tells the controller to start programming once chip select rises on a clean byte boundary. The controller reports back the protection bits, the write-enable latch and a busy flag. While busy is set, the front end answers only the status read.

Both idle levels of the serial clock are accepted: low (mode 0) and high (mode 3). The serial clock half period must be at least ten system clock cycles.

Top module: `spi_eeprom_frontend`

## Requirements
- R1: After reset, so_en, mem_rd, req_valid and req_commit are all 0.
- R2: Input bits are captured MSB first on rising serial clock edges, starting with the first rising edge after chip select falls. Output bits change only after falling edges. so_en stays 0 while instruction and address bits are received. Both clock idle levels work.
- R3: Read opcode 0000A011 (A = address bit 8), followed by address bits 7..0, streams memory bytes MSB first from that address, incrementing by one per byte. Each byte costs one single-cycle mem_rd.
- R4: A read that passes address 0x1FF continues at 0x000.
- R5: Status read opcode 0x05 returns {4'b0000, protect[1], protect[0], write-enable, busy} from bit 7 down to bit 0, repeated for every further byte in the selection.
- R6: While stat_busy is 1, the status read returns 0x01, and every other opcode gives no request, no memory fetch and no output.
- R7: Opcode 0x06 issues one request of kind 0 and opcode 0x04 one request of kind 1, when the eighth opcode bit arrives.
- R8: Write opcode 0000A010, followed by an address byte, issues one kind-3 request per data byte. The address has fixed bits above the 4-byte page, and its two low bits advance by one per byte and wrap inside the page.
- R9: Opcode 0x01 followed by one data byte issues one kind-2 request carrying that byte.
- R10: req_commit pulses once when chip select rises after at least one complete write-type data byte with no partial byte pending. Otherwise it stays 0.
- R11: An unrecognised opcode causes no request, no fetch and no output until the next selection.
- R12: A rising chip select at any bit position clears the decoder, so the next selection starts with a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out value |
| so_en | output | 1 | Serial data out drive enable (0 = high impedance) |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 9 | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_rd |
| stat_bp | input | 2 | Block protection bits from the programming controller |
| stat_wen | input | 1 | Write-enable latch from the programming controller |
| stat_busy | input | 1 | Programming cycle in progress |
| req_valid | output | 1 | Request strobe |
| req_kind | output | 2 | 0 enable set, 1 enable clear, 2 status write, 3 array write |
| req_addr | output | 9 | Array write address |
| req_data | output | 8 | Write data byte |
| req_commit | output | 1 | Start programming pulse |

## Verification
The hardest situations to reach from the pins are the ones where chip select rises at an awkward point. One is in the middle of a byte that follows a complete write byte: the commit must be withheld and the data already requested must stand. The other is partway through an opcode, where the next selection must decode from bit zero. The bench reaches both with a bit-level task that clocks any number of bits before deselecting. It then runs a fresh status read and checks that the bytes line up. Address wrap at 0x1FF and the page wrap of write addresses are reached by choosing start addresses two bytes below each boundary.

// File: rtl/spiee_pkg.sv
`timescale 1ns/1ps
package spiee_pkg;

   typedef enum logic [2:0] {
      ST_OPC    = 3'd0,
      ST_ADDR   = 3'd1,
      ST_RDATA  = 3'd2,
      ST_RSTAT  = 3'd3,
      ST_WADDR  = 3'd4,
      ST_WDATA  = 3'd5,
      ST_SRDATA = 3'd6,
      ST_IGNORE = 3'd7
   } fe_state_t;

   typedef enum logic [1:0] {
      REQ_WEN_SET = 2'd0,
      REQ_WEN_CLR = 2'd1,
      REQ_STATUS  = 2'd2,
      REQ_ARRAY   = 2'd3
   } req_kind_t;

   localparam logic [7:0] OPC_WEN_SET = 8'h06;
   localparam logic [7:0] OPC_WEN_CLR = 8'h04;
   localparam logic [7:0] OPC_STAT_RD = 8'h05;
   localparam logic [7:0] OPC_STAT_WR = 8'h01;

   function automatic logic is_array_read(input logic [7:0] op);
      return (op[7:4] == 4'h0) && (op[2:0] == 3'b011);
   endfunction

   function automatic logic is_array_write(input logic [7:0] op);
      return (op[7:4] == 4'h0) && (op[2:0] == 3'b010);
   endfunction

   function automatic logic [7:0] pack_status(input logic [1:0] bp,
                                              input logic wen,
                                              input logic busy);
      return busy ? 8'h01 : {4'h0, bp, wen, 1'b0};
   endfunction

endpackage

// File: rtl/spiee_sync.sv
`timescale 1ns/1ps
module spiee_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= RST_VAL[g];
            else        chain <= d[g];
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], d[g]};
      end
      assign q[g] = chain[STAGES-1];
   end
endmodule

// File: rtl/spiee_rx.sv
`timescale 1ns/1ps
module spiee_rx #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         sample,
   input  logic         din,
   output logic         byte_done,
   output logic [W-1:0] rx_byte,
   output logic         mid_byte
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [CW-1:0] cnt;
   logic [W-2:0]  sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         sh        <= '0;
         rx_byte   <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (clear) begin
            cnt <= '0;
            sh  <= '0;
         end else if (sample) begin
            if (cnt == LAST) begin
               rx_byte   <= {sh, din};
               byte_done <= 1'b1;
               cnt       <= '0;
            end else begin
               sh  <= {sh[W-3:0], din};
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign mid_byte = (cnt != '0);
endmodule

// File: rtl/spiee_tx.sv
`timescale 1ns/1ps
module spiee_tx #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         load,
   input  logic [W-1:0] load_byte,
   input  logic         shift,
   output logic         so,
   output logic         so_en
);
   logic [W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         so    <= 1'b0;
         so_en <= 1'b0;
      end else if (clear) begin
         sh    <= '0;
         so    <= 1'b0;
         so_en <= 1'b0;
      end else begin
         if (load)       sh <= load_byte;
         else if (shift) sh <= {sh[W-2:0], 1'b0};
         if (shift) begin
            so    <= sh[W-1];
            so_en <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/spiee_ctrl.sv
`timescale 1ns/1ps
module spiee_ctrl
   import spiee_pkg::*;
#(
   parameter int ADDR_W     = 9,
   parameter int PAGE_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              desel,
   input  logic              byte_done,
   input  logic [7:0]        rx_byte,
   input  logic              mid_byte,
   input  logic [1:0]        stat_bp,
   input  logic              stat_wen,
   input  logic              stat_busy,
   input  logic [7:0]        mem_rdata,
   output fe_state_t         st,
   output logic              out_active,
   output logic              tx_load,
   output logic [7:0]        tx_byte,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              req_valid,
   output logic [1:0]        req_kind,
   output logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        req_data,
   output logic              req_commit
);
   localparam int PB = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
   localparam logic [ADDR_W-1:0] PG_MASK = ADDR_W'(PAGE_BYTES - 1);

   logic              addr_hi;
   logic [ADDR_W-1:0] full_addr;
   logic [ADDR_W-1:0] rd_ptr;
   logic [ADDR_W-1:0] wr_base;
   logic [PB-1:0]     wr_lo;
   logic [ADDR_W-1:0] page_addr;
   logic              armed;
   logic              rd_wait;
   logic              st_load;
   logic [7:0]        st_byte;

   // the ninth address bit, when present, rides in bit 3 of the opcode
   if (ADDR_W > 8) begin : g_hi_in_opc
      assign full_addr = {addr_hi, rx_byte};
   end else begin : g_byte_addr
      logic unused_hi;
      assign unused_hi = addr_hi;
      assign full_addr = rx_byte;
   end

   assign page_addr = (wr_base & ~PG_MASK) | ((wr_base + ADDR_W'(wr_lo)) & PG_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_OPC;
         addr_hi    <= 1'b0;
         rd_ptr     <= '0;
         wr_base    <= '0;
         wr_lo      <= '0;
         armed      <= 1'b0;
         rd_wait    <= 1'b0;
         st_load    <= 1'b0;
         st_byte    <= '0;
         mem_rd     <= 1'b0;
         mem_addr   <= '0;
         req_valid  <= 1'b0;
         req_kind   <= '0;
         req_addr   <= '0;
         req_data   <= '0;
         req_commit <= 1'b0;
      end else begin
         mem_rd     <= 1'b0;
         st_load    <= 1'b0;
         req_valid  <= 1'b0;
         req_commit <= 1'b0;
         rd_wait    <= mem_rd;
         if (desel) begin
            // R10/R12: deselect ends the command and may start programming
            req_commit <= armed & ~mid_byte;
            armed      <= 1'b0;
            wr_lo      <= '0;
            rd_wait    <= 1'b0;
            st         <= ST_OPC;
         end else if (byte_done) begin
            unique case (st)
               ST_OPC: begin
                  addr_hi <= rx_byte[3];
                  if (stat_busy && rx_byte != OPC_STAT_RD) begin
                     st <= ST_IGNORE;
                  end else if (rx_byte == OPC_STAT_RD) begin
                     st_byte <= pack_status(stat_bp, stat_wen, stat_busy);
                     st_load <= 1'b1;
                     st      <= ST_RSTAT;
                  end else if (rx_byte == OPC_WEN_SET || rx_byte == OPC_WEN_CLR) begin
                     req_valid <= 1'b1;
                     req_kind  <= (rx_byte == OPC_WEN_SET) ? REQ_WEN_SET : REQ_WEN_CLR;
                     st        <= ST_IGNORE;
                  end else if (rx_byte == OPC_STAT_WR) begin
                     st <= ST_SRDATA;
                  end else if (is_array_read(rx_byte)) begin
                     st <= ST_ADDR;
                  end else if (is_array_write(rx_byte)) begin
                     st <= ST_WADDR;
                  end else begin
                     st <= ST_IGNORE;
                  end
               end
               ST_ADDR: begin
                  mem_rd   <= 1'b1;
                  mem_addr <= full_addr;
                  rd_ptr   <= full_addr + 1'b1;
                  st       <= ST_RDATA;
               end
               ST_RDATA: begin
                  mem_rd   <= 1'b1;
                  mem_addr <= rd_ptr;
                  rd_ptr   <= rd_ptr + 1'b1;
               end
               ST_RSTAT: begin
                  st_byte <= pack_status(stat_bp, stat_wen, stat_busy);
                  st_load <= 1'b1;
               end
               ST_WADDR: begin
                  wr_base <= full_addr;
                  wr_lo   <= '0;
                  st      <= ST_WDATA;
               end
               ST_WDATA: begin
                  req_valid <= 1'b1;
                  req_kind  <= REQ_ARRAY;
                  req_addr  <= page_addr;
                  req_data  <= rx_byte;
                  wr_lo     <= wr_lo + 1'b1;
                  armed     <= 1'b1;
               end
               ST_SRDATA: begin
                  req_valid <= 1'b1;
                  req_kind  <= REQ_STATUS;
                  req_data  <= rx_byte;
                  armed     <= 1'b1;
                  st        <= ST_IGNORE;
               end
               default: ;
            endcase
         end
      end
   end

   assign out_active = (st == ST_RDATA) || (st == ST_RSTAT);
   assign tx_load    = rd_wait | st_load;
   assign tx_byte    = rd_wait ? mem_rdata : st_byte;
endmodule

// File: rtl/spi_eeprom_frontend.sv
`timescale 1ns/1ps
module spi_eeprom_frontend
   import spiee_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int DATA_W      = 8,
   parameter int PAGE_BYTES  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   output logic              so,
   output logic              so_en,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [1:0]        stat_bp,
   input  logic              stat_wen,
   input  logic              stat_busy,
   output logic              req_valid,
   output logic [1:0]        req_kind,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic              req_commit
);
   if (DATA_W != 8) begin : g_chk_data
      $error("spi_eeprom_frontend: DATA_W must be 8");
   end
   if (ADDR_W < 8 || ADDR_W > 9) begin : g_chk_addr
      $error("spi_eeprom_frontend: ADDR_W must be 8 or 9");
   end
   if (PAGE_BYTES < 1 || PAGE_BYTES > 256 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_chk_page
      $error("spi_eeprom_frontend: PAGE_BYTES must be a power of two up to 256");
   end
   if (SYNC_STAGES < 1) begin : g_chk_sync
      $error("spi_eeprom_frontend: SYNC_STAGES must be at least 1");
   end

   logic [2:0] raw_in, syn_in;
   logic       cs_q, sck_q, si_q;
   logic       cs_d, sck_d;
   logic       sel, desel, sck_rise, sck_fall;
   logic       byte_done, mid_byte, out_active, tx_load;
   logic [7:0] rx_byte, tx_byte;
   fe_state_t  st;

   assign raw_in = {cs_n, sck, si};

   spiee_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
   );
   assign {cs_q, sck_q, si_q} = syn_in;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= cs_q;
         sck_d <= sck_q;
      end

   assign sel      = ~cs_q;
   assign desel    = cs_q & ~cs_d;
   assign sck_rise = sck_q & ~sck_d;
   assign sck_fall = ~sck_q & sck_d;

   spiee_rx #(.W(8)) u_rx (
      .clk(clk), .rst_n(rst_n), .clear(~sel), .sample(sck_rise & sel), .din(si_q),
      .byte_done(byte_done), .rx_byte(rx_byte), .mid_byte(mid_byte)
   );

   spiee_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .desel(desel), .byte_done(byte_done),
      .rx_byte(rx_byte), .mid_byte(mid_byte),
      .stat_bp(stat_bp), .stat_wen(stat_wen), .stat_busy(stat_busy),
      .mem_rdata(mem_rdata), .st(st), .out_active(out_active),
      .tx_load(tx_load), .tx_byte(tx_byte),
      .mem_rd(mem_rd), .mem_addr(mem_addr),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .req_data(req_data), .req_commit(req_commit)
   );

   spiee_tx #(.W(8)) u_tx (
      .clk(clk), .rst_n(rst_n), .clear(~sel), .load(tx_load), .load_byte(tx_byte),
      .shift(sck_fall & sel & out_active), .so(so), .so_en(so_en)
   );
endmodule

// File: rtl/spiee_checker.sv
`timescale 1ns/1ps
module spiee_checker
   import spiee_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       so,
   input logic       so_en,
   input logic       mem_rd,
   input logic       req_commit,
   input logic       sel,
   input logic       sck_fall,
   input logic [2:0] st_code
);
   // R12: once deselected the output is released on the next cycle
   p_release_on_desel_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !so_en);

   // R2: a driven output bit moves only right after a falling clock edge
   p_so_moves_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (so_en && $past(so_en) && !$past(sck_fall)) |-> $stable(so));

   // R11: an ignored command never drives the line
   p_ignore_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_code == 3'(ST_IGNORE)) |-> !so_en);

   // R3: one single-cycle fetch per byte
   p_single_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   // R10: programming start only follows a deselect
   p_commit_after_desel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_commit |-> !$past(sel));
endmodule

bind spi_eeprom_frontend spiee_checker u_chk (
   .clk(clk), .rst_n(rst_n), .so(so), .so_en(so_en), .mem_rd(mem_rd),
   .req_commit(req_commit), .sel(sel), .sck_fall(sck_fall), .st_code(st)
);

// File: tb/spi_eeprom_frontend_bench.sv
`timescale 1ns/1ps
module spi_eeprom_frontend_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 10;   // system clocks per serial clock half period

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0;
   logic       so, so_en, mem_rd;
   logic [8:0] mem_addr;
   logic [7:0] mem_rdata = 8'h00;
   logic [1:0] stat_bp = 2'b00;
   logic       stat_wen = 1'b0, stat_busy = 1'b0;
   logic       req_valid, req_commit;
   logic [1:0] req_kind;
   logic [8:0] req_addr;
   logic [7:0] req_data;

   int n_checks = 0, n_errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_eeprom_frontend u_spi_eeprom_frontend (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_en(so_en),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .stat_bp(stat_bp), .stat_wen(stat_wen), .stat_busy(stat_busy),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .req_data(req_data), .req_commit(req_commit)
   );

   function automatic logic [7:0] mem_val(input int a);
      return 8'((a * 37 + 5) & 255);
   endfunction

   always @(posedge clk) if (mem_rd) mem_rdata <= mem_val(int'(mem_addr));

   // request monitor
   int mon_req = 0, mon_commit = 0, mon_rd = 0;
   bit mon_oe = 1'b0;
   int rk [16];
   int ra [16];
   int rd [16];
   always @(posedge clk) begin
      if (req_valid) begin
         if (mon_req < 16) begin
            rk[mon_req] = int'(req_kind);
            ra[mon_req] = int'(req_addr);
            rd[mon_req] = int'(req_data);
         end
         mon_req++;
      end
      if (req_commit) mon_commit++;
      if (mem_rd) mon_rd++;
      if (so_en) mon_oe = 1'b1;
   end

   task automatic clr_mon();
      mon_req = 0; mon_commit = 0; mon_rd = 0; mon_oe = 1'b0;
   endtask

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_h();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic select(input bit m3);
      sck = m3;
      wait_h();
      cs_n = 1'b0;
      wait_h();
   endtask

   task automatic deselect(input bit m3);
      if (!m3) begin
         sck = 1'b0;
         wait_h();
      end
      cs_n = 1'b1;
      repeat (4) wait_h();
   endtask

   // clocks n bits of tx MSB first; returns sampled output bits and drive flags
   task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx,
                            output bit en_all, output bit en_any);
      rx = 8'h00; en_all = 1'b1; en_any = 1'b0;
      for (int i = 7; i > 7 - n; i--) begin
         sck = 1'b0;
         si  = tx[i];
         wait_h();
         rx[i] = so;
         if (so_en) en_any = 1'b1; else en_all = 1'b0;
         sck = 1'b1;
         wait_h();
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit en_all, output bit en_any);
      xfer_bits(tx, 8, rx, en_all, en_any);
   endtask

   task automatic t_reset();
      chk(so_en == 1'b0, "R1", "so_en after reset", int'(so_en), 0);
      chk(mem_rd == 1'b0 && req_valid == 1'b0 && req_commit == 1'b0, "R1",
          "strobes after reset", int'({mem_rd, req_valid, req_commit}), 0);
   endtask

   task automatic t_read(input bit m3, input int start, input int nbytes, input string req);
      logic [7:0] rx; bit ea, en;
      clr_mon();
      select(m3);
      xfer({4'h0, 1'(start >> 8), 3'b011}, rx, ea, en);
      chk(!en, "R2", "so_en during opcode", int'(en), 0);
      xfer(8'(start), rx, ea, en);
      chk(!en, "R2", "so_en during address", int'(en), 0);
      for (int k = 0; k < nbytes; k++) begin
         xfer(8'hFF, rx, ea, en);
         chk(ea && rx == mem_val((start + k) & 511), req, $sformatf("read byte %0d", k),
             int'(rx), int'(mem_val((start + k) & 511)));
      end
      deselect(m3);
      chk(mon_rd == nbytes + 1, "R3", "fetch count", mon_rd, nbytes + 1);
      chk(so_en == 1'b0, "R12", "so_en after deselect", int'(so_en), 0);
   endtask

   task automatic t_rdsr(input logic [1:0] bp, input bit wen, input bit busy, input string req);
      logic [7:0] rx, exp; bit ea, en;
      stat_bp = bp; stat_wen = wen; stat_busy = busy;
      exp = busy ? 8'h01 : {4'h0, bp, wen, 1'b0};
      select(1'b0);
      xfer(8'h05, rx, ea, en);
      for (int k = 0; k < 2; k++) begin
         xfer(8'h00, rx, ea, en);
         chk(ea && rx == exp, req, $sformatf("status byte %0d", k), int'(rx), int'(exp));
      end
      deselect(1'b0);
      stat_busy = 1'b0;
   endtask

   task automatic t_busy();
      logic [7:0] rx; bit ea, en;
      t_rdsr(2'b11, 1'b1, 1'b1, "R6");
      stat_busy = 1'b1;
      clr_mon();
      select(1'b0);
      xfer(8'h03, rx, ea, en);
      xfer(8'h10, rx, ea, en);
      xfer(8'hFF, rx, ea, en);
      deselect(1'b0);
      select(1'b0);
      xfer(8'h06, rx, ea, en);
      deselect(1'b0);
      stat_busy = 1'b0;
      chk(!mon_oe && mon_rd == 0, "R6", "read while busy output/fetch", int'(mon_oe) + mon_rd, 0);
      chk(mon_req == 0, "R6", "requests while busy", mon_req, 0);
   endtask

   task automatic t_wen();
      logic [7:0] rx; bit ea, en;
      clr_mon();
      select(1'b0); xfer(8'h06, rx, ea, en); deselect(1'b0);
      select(1'b1); xfer(8'h04, rx, ea, en); deselect(1'b1);
      chk(mon_req == 2, "R7", "request count", mon_req, 2);
      chk(rk[0] == 0 && rk[1] == 1, "R7", "request kinds", rk[0] * 16 + rk[1], 1);
      chk(mon_commit == 0, "R10", "no commit for enable commands", mon_commit, 0);
   endtask

   task automatic t_write_page();
      logic [7:0] rx; bit ea, en;
      int exp_a;
      clr_mon();
      select(1'b0);
      xfer(8'h02, rx, ea, en);
      xfer(8'hFE, rx, ea, en);
      for (int k = 0; k < 6; k++) xfer(8'(8'h11 * (k + 1)), rx, ea, en);
      deselect(1'b0);
      chk(mon_req == 6, "R8", "write request count", mon_req, 6);
      for (int k = 0; k < 6; k++) begin
         exp_a = (9'h0FE & ~3) | ((9'h0FE + k) & 3);
         chk(rk[k] == 3 && ra[k] == exp_a && rd[k] == ((17 * (k + 1)) & 255), "R8",
             $sformatf("write request %0d addr", k), ra[k], exp_a);
      end
      chk(mon_commit == 1, "R10", "commit after whole bytes", mon_commit, 1);
   endtask

   task automatic t_write_partial();
      logic [7:0] rx; bit ea, en;
      clr_mon();
      select(1'b1);
      xfer(8'h0A, rx, ea, en);
      xfer(8'h40, rx, ea, en);
      xfer(8'h5A, rx, ea, en);
      xfer_bits(8'hA0, 3, rx, ea, en);
      deselect(1'b1);
      chk(mon_req == 1 && ra[0] == 9'h140 && rd[0] == 8'h5A, "R8", "high address bit write",
          ra[0], 9'h140);
      chk(mon_commit == 0, "R10", "no commit with partial byte", mon_commit, 0);
   endtask

   task automatic t_wrsr();
      logic [7:0] rx; bit ea, en;
      clr_mon();
      select(1'b0);
      xfer(8'h01, rx, ea, en);
      xfer(8'h0C, rx, ea, en);
      deselect(1'b0);
      chk(mon_req == 1 && rk[0] == 2 && rd[0] == 8'h0C, "R9", "status write request",
          rd[0], 8'h0C);
      chk(mon_commit == 1, "R10", "commit after status write", mon_commit, 1);
   endtask

   task automatic t_invalid();
      logic [7:0] rx; bit ea, en;
      clr_mon();
      select(1'b0);
      xfer(8'h07, rx, ea, en);
      xfer(8'h06, rx, ea, en);
      xfer(8'h05, rx, ea, en);
      xfer(8'h00, rx, ea, en);
      deselect(1'b0);
      chk(!mon_oe && mon_req == 0 && mon_rd == 0, "R11", "activity after bad opcode",
          int'(mon_oe) + mon_req + mon_rd, 0);
      t_rdsr(2'b01, 1'b0, 1'b0, "R11");
   endtask

   task automatic t_abort();
      logic [7:0] rx; bit ea, en;
      clr_mon();
      select(1'b0);
      xfer_bits(8'h00, 5, rx, ea, en);
      deselect(1'b0);
      chk(!mon_oe && mon_req == 0, "R12", "aborted opcode activity", int'(mon_oe) + mon_req, 0);
      t_rdsr(2'b10, 1'b1, 1'b0, "R12");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_read(1'b0, 9'h123, 3, "R3");
      t_read(1'b1, 9'h045, 2, "R2");
      t_read(1'b0, 9'h1FE, 4, "R4");
      t_rdsr(2'b10, 1'b1, 1'b0, "R5");
      t_busy();
      t_wen();
      t_write_page();
      t_write_partial();
      t_wrsr();
      t_invalid();
      t_abort();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule